// File: doc/BRIEF.md
# Multiplexed-Bus Target Transaction Engine

This block is a simplified 32-bit target for a shared PCI-style bus on which address and data share one set of lines. On the clock where the cycle-frame strobe goes active, it latches the address and the 4-bit command. It classifies the command and decides whether the cycle belongs to it. A cycle is claimed when it is a memory or I/O command and its address lies inside the matching window. Once it has claimed a cycle, the engine runs one or more data phases against a small word-wide register file. During those phases the same four command lines serve as active-low byte-lane enables.

Pads are modelled as separate input, output and output-enable signals. The target asserts device-select and target-ready together in the clock after the address clock. It completes a data phase on every clock where both ready strobes are low, and it steps the word address after each completed phase. When the final phase is done it drives both strobes high for one clock and then releases them. Parity, configuration space, retry, disconnect, abort and arbitration are not part of the block.

Top module: `pci_tgt_engine`

## Requirements
- R1: After reset, and until a cycle is claimed, `tgt_oe_o` and `ad_oe_o` are 0 and `devsel_n_o` and `trdy_n_o` are 1.
- R2: A claimed cycle shows `devsel_n_o`=0, `trdy_n_o`=0 and `tgt_oe_o`=1 in the clock that follows the address clock. The address clock is the first clock where `frame_n_i` is sampled low after it was sampled high.
- R3: The reserved command codes 0100, 0101, 1000, 1001 and 1101 are never claimed. The register file is not modified by them, even when the address hits a window.
- R4: Interrupt acknowledge (0000), special cycle (0001), configuration read (1010) and configuration write (1011) are decoded but never claimed.
- R5: A memory command whose address bits [31:WIN_BITS] differ from those of `MEM_BASE` is not claimed.
- R6: I/O read (0010) and I/O write (0011) are claimed only inside the `IO_BASE` window. Memory commands are claimed only inside the `MEM_BASE` window. Both windows index the same register file through address bits [WIN_BITS-1:2].
- R7: In a write data phase, `cbe_n_i` bit k low enables byte lane k, which is AD bits [8k+7:8k]. Only the enabled lanes of the addressed word are written.
- R8: In a read data phase, `ad_oe_o` is 1 and `ad_o` carries the full addressed word, whatever the byte enables. `ad_oe_o` stays 0 for write cycles.
- R9: A data phase completes only on a clock where `irdy_n_i` and `trdy_n_o` are both low. A wait clock (`irdy_n_i`=1) neither writes nor advances the address.
- R10: After each completed data phase, the word address steps by one (byte address +4). It wraps within the window.
- R11: When a phase completes with `frame_n_i` high, the next clock shows `devsel_n_o`=1, `trdy_n_o`=1 and `tgt_oe_o`=1. The clock after that shows `tgt_oe_o`=0.
- R12: Memory read (0110), memory read multiple (1100) and memory read line (1110) all behave as reads. Memory write (0111) and memory write and invalidate (1111) both behave as writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Cycle frame from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data lines as seen at the pad |
| cbe_n_i | input | 4 | Command in the address clock, byte enables (active low) in data clocks |
| ad_o | output | 32 | Read data driven onto the address/data lines |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| tgt_oe_o | output | 1 | Output enable for `devsel_n_o` and `trdy_n_o` |

## Verification
The hardest case to reach from the ports is a cycle that is not claimed but still carries data clocks, such as a reserved code or an out-of-window address. The engine must sit silent through every data clock and must not treat one of them as a fresh address. The stimulus drives each such probe as a complete write cycle with data on the bus. Directly afterwards it reads back the whole register file through a claimed burst and compares it with a model. That shows no stray write happened and that the engine came back ready for the next frame. Wait states and address wrap-around are reached by holding the initiator-ready strobe high for one data clock, and by starting a burst at the last word of the window.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  localparam logic [3:0] CMD_IACK     = 4'b0000;
  localparam logic [3:0] CMD_SPECIAL  = 4'b0001;
  localparam logic [3:0] CMD_IO_RD    = 4'b0010;
  localparam logic [3:0] CMD_IO_WR    = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD   = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR   = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD   = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR   = 4'b1011;
  localparam logic [3:0] CMD_MEM_RDM  = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL  = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI  = 4'b1111;

  typedef enum logic [1:0] {
    SPC_NONE,
    SPC_MEM,
    SPC_IO
  } space_e;

  typedef struct packed {
    logic   known;
    space_e space;
    logic   is_rd;
  } cmd_info_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_TURN,
    ST_SKIP
  } tgt_state_e;

  function automatic cmd_info_t classify_cmd(input logic [3:0] c);
    cmd_info_t r;
    r = '{known: 1'b1, space: SPC_NONE, is_rd: 1'b0};
    case (c)
      CMD_IACK, CMD_SPECIAL, CMD_CFG_RD, CMD_CFG_WR: r.space = SPC_NONE;
      CMD_IO_RD:  begin r.space = SPC_IO;  r.is_rd = 1'b1; end
      CMD_IO_WR:  r.space = SPC_IO;
      CMD_MEM_RD, CMD_MEM_RDM, CMD_MEM_RDL: begin
        r.space = SPC_MEM;
        r.is_rd = 1'b1;
      end
      CMD_MEM_WR, CMD_MEM_WRI: r.space = SPC_MEM;
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pci_tgt_cmd_dec.sv
module pci_tgt_cmd_dec
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'h1000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_2000,
  parameter int          WIN_BITS = 6
) (
  input  logic [31:0] ad,
  input  logic [3:0]  cmd,
  output logic        claim,
  output logic        is_rd,
  output logic        rsvd
);

  localparam int TAG_W = 32 - WIN_BITS;

  cmd_info_t info;
  logic      mem_hit;
  logic      io_hit;

  always_comb begin
    info    = classify_cmd(cmd);
    mem_hit = (ad[31:WIN_BITS] == MEM_BASE[31:WIN_BITS]);
    io_hit  = (ad[31:WIN_BITS] == IO_BASE[31:WIN_BITS]);
    rsvd    = !info.known;
    is_rd   = info.is_rd;
    claim   = 1'b0;
    if (info.known) begin
      case (info.space)
        SPC_MEM: claim = mem_hit;
        SPC_IO:  claim = io_hit;
        default: claim = 1'b0;
      endcase
    end
  end

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = TAG_W'(0);

endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile #(
  parameter int IDX_W = 4,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [LANES-1:0]     lane_en,
  input  logic [LANES*8-1:0]   wdata,
  input  logic [IDX_W-1:0]     ridx,
  output logic [LANES*8-1:0]   rdata
);

  localparam int DEPTH = 1 << IDX_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_l [DEPTH];
    logic [7:0] rd_l;

    always_ff @(posedge clk) begin
      if (we && lane_en[l]) begin
        mem_l[widx] <= wdata[8*l +: 8];
      end
      rd_l <= mem_l[ridx];
    end

    assign rdata[8*l +: 8] = rd_l;
  end

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             claim,
  input  logic             cmd_rd,
  input  logic             cmd_rsvd,
  input  logic [IDX_W-1:0] addr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_en,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             tgt_oe,
  output logic             ad_oe
);

  tgt_state_e       state;
  logic             frame_q;
  logic [IDX_W-1:0] idx;
  logic             rd_q;
  logic             start;
  logic             done;

  assign start  = (state == ST_IDLE) && !frame_n && frame_q;
  assign done   = (state == ST_XFER) && !irdy_n && !trdy_n;
  assign wr_en  = done && !rd_q;
  assign wr_idx = idx;

  always_comb begin
    case (state)
      ST_IDLE: rd_idx = addr_idx;
      ST_XFER: rd_idx = done ? idx + IDX_W'(1) : idx;
      default: rd_idx = idx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      frame_q  <= 1'b1;
      idx      <= '0;
      rd_q     <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      tgt_oe   <= 1'b0;
      ad_oe    <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (claim) begin
              state    <= ST_XFER;
              idx      <= addr_idx;
              rd_q     <= cmd_rd;
              devsel_n <= 1'b0;
              trdy_n   <= 1'b0;
              tgt_oe   <= 1'b1;
              ad_oe    <= cmd_rd;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_XFER: begin
          if (done) begin
            idx <= idx + IDX_W'(1);
            if (frame_n) begin
              state    <= ST_TURN;
              devsel_n <= 1'b1;
              trdy_n   <= 1'b1;
              ad_oe    <= 1'b0;
            end
          end
        end
        ST_TURN: begin
          tgt_oe <= 1'b0;
          state  <= ST_IDLE;
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tgt_oe && !ad_oe && devsel_n && trdy_n)); // R1

  AST_DEVSEL_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !devsel_n |-> tgt_oe); // R2

  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (start && cmd_rsvd) |=> (devsel_n && !tgt_oe)); // R3

  AST_AD_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (rd_q && !trdy_n)); // R8

  AST_WAIT_HOLDS_IDX: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_XFER) && irdy_n) |=> $stable(idx)); // R9

  AST_LAST_PHASE_TURN: assert property (@(posedge clk) disable iff (rst)
    (done && frame_n) |=> (devsel_n && trdy_n && tgt_oe)); // R11

  AST_RELEASE_AFTER_TURN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) |=> !tgt_oe); // R11

endmodule

// File: rtl/pci_tgt_engine.sv
module pci_tgt_engine #(
  parameter logic [31:0] MEM_BASE = 32'h1000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_2000,
  parameter int          WIN_BITS = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_n_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  output logic        devsel_n_o,
  output logic        trdy_n_o,
  output logic        tgt_oe_o
);

  localparam int IDX_W = WIN_BITS - 2;
  localparam int LANES = 4;

  logic             claim;
  logic             cmd_rd;
  logic             cmd_rsvd;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;

  pci_tgt_cmd_dec #(
    .MEM_BASE (MEM_BASE),
    .IO_BASE  (IO_BASE),
    .WIN_BITS (WIN_BITS)
  ) u_dec (
    .ad    (ad_i),
    .cmd   (cbe_n_i),
    .claim (claim),
    .is_rd (cmd_rd),
    .rsvd  (cmd_rsvd)
  );

  pci_tgt_ctrl #(
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n_i),
    .irdy_n   (irdy_n_i),
    .claim    (claim),
    .cmd_rd   (cmd_rd),
    .cmd_rsvd (cmd_rsvd),
    .addr_idx (ad_i[WIN_BITS-1:2]),
    .rd_idx   (rd_idx),
    .wr_idx   (wr_idx),
    .wr_en    (wr_en),
    .devsel_n (devsel_n_o),
    .trdy_n   (trdy_n_o),
    .tgt_oe   (tgt_oe_o),
    .ad_oe    (ad_oe_o)
  );

  pci_tgt_regfile #(
    .IDX_W (IDX_W),
    .LANES (LANES)
  ) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .widx    (wr_idx),
    .lane_en (~cbe_n_i),
    .wdata   (ad_i),
    .ridx    (rd_idx),
    .rdata   (ad_o)
  );

endmodule

// File: tb/pci_tgt_engine_tb.sv
module pci_tgt_engine_tb;

  localparam logic [31:0] MEM_BASE = 32'h1000_0000;
  localparam logic [31:0] IO_BASE  = 32'h0000_2000;
  localparam int          WORDS    = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n, trdy_n, tgt_oe;

  int total = 0;
  int bad   = 0;
  logic [31:0] model [WORDS];

  always #10 clk = ~clk;

  pci_tgt_engine #(
    .MEM_BASE (MEM_BASE),
    .IO_BASE  (IO_BASE),
    .WIN_BITS (6)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .frame_n_i  (frame_n),
    .irdy_n_i   (irdy_n),
    .ad_i       (ad),
    .cbe_n_i    (cbe_n),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe),
    .devsel_n_o (devsel_n),
    .trdy_n_o   (trdy_n),
    .tgt_oe_o   (tgt_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = be_n[k] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  // Claimed write burst; wait_first inserts one wait clock before phase 0.
  task automatic do_write(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                          input logic [31:0] base_data, input logic [3:0] be_n,
                          input bit wait_first, input string tag);
    int idx0 = int'(addr[5:2]);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
    if (wait_first) begin
      @(negedge clk);
      irdy_n = 1'b1; ad = 32'hBAD0_BAD0; cbe_n = 4'h0;
      check(!devsel_n && !trdy_n && tgt_oe, {tag, " R2 claim before wait"},
            {29'd0, devsel_n, trdy_n, tgt_oe}, 32'd1);
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      int          w;
      d = base_data + 32'(i) * 32'h0101_0101;
      w = (idx0 + i) % WORDS;
      @(negedge clk);
      frame_n = (i == n - 1); irdy_n = 1'b0; ad = d; cbe_n = be_n;
      check(!devsel_n && !trdy_n && tgt_oe && !ad_oe, {tag, " R2 R8 write phase strobes"},
            {28'd0, devsel_n, trdy_n, tgt_oe, ad_oe}, 32'd2);
      model[w] = (model[w] & ~lane_mask(be_n)) | (d & lane_mask(be_n));
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
    check(devsel_n && trdy_n && tgt_oe, {tag, " R11 turnaround"},
          {29'd0, devsel_n, trdy_n, tgt_oe}, 32'd7);
    @(negedge clk);
    check(!tgt_oe, {tag, " R11 release"}, {31'd0, tgt_oe}, 32'd0);
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                         input string tag);
    int idx0 = int'(addr[5:2]);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
    for (int i = 0; i < n; i++) begin
      int w = (idx0 + i) % WORDS;
      @(negedge clk);
      frame_n = (i == n - 1); irdy_n = 1'b0; ad = '0; cbe_n = 4'b1110;
      check(ad_oe && !trdy_n, {tag, " R8 read drive"}, {30'd0, ad_oe, trdy_n}, 32'd2);
      check(ad_o == model[w], {tag, " R8 R10 R12 read data"}, ad_o, model[w]);
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    check(devsel_n && trdy_n && tgt_oe && !ad_oe, {tag, " R11 read turnaround"},
          {28'd0, devsel_n, trdy_n, tgt_oe, ad_oe}, 32'd14);
    @(negedge clk);
    check(!tgt_oe, {tag, " R11 read release"}, {31'd0, tgt_oe}, 32'd0);
  endtask

  // Full write-shaped cycle that must not be claimed.
  task automatic do_probe(input logic [31:0] addr, input logic [3:0] cmd,
                          input string tag);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; ad = 32'hDEAD_0000 | 32'(cmd); cbe_n = 4'h0;
    check(!tgt_oe && devsel_n, {tag, " silent in data clock"},
          {30'd0, tgt_oe, devsel_n}, 32'd1);
    @(negedge clk);
    irdy_n = 1'b1; cbe_n = 4'hF; ad = '0;
    check(!tgt_oe && devsel_n, {tag, " silent after data clock"},
          {30'd0, tgt_oe, devsel_n}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!tgt_oe && !ad_oe && devsel_n && trdy_n, "R1 reset state",
          {28'd0, tgt_oe, ad_oe, devsel_n, trdy_n}, 32'd3);
  endtask

  task automatic t_fill_and_read();
    do_write(MEM_BASE, 4'b0111, WORDS, 32'h0102_0304, 4'h0, 1'b0, "R10 fill");
    do_read(MEM_BASE + 32'h8, 4'b0110, 4, "R12 memread");
  endtask

  task automatic t_byte_lanes();
    do_write(MEM_BASE + 32'hC, 4'b1111, 1, 32'hAABB_CCDD, 4'b1010, 1'b0, "R7 lanes");
    do_read(MEM_BASE + 32'hC, 4'b1100, 1, "R7 R12 readback");
  endtask

  task automatic t_wrap();
    do_write(MEM_BASE + 32'h3C, 4'b0111, 3, 32'h5500_0011, 4'h0, 1'b0, "R10 wrap");
    do_read(MEM_BASE + 32'h3C, 4'b1110, 3, "R10 wrap readback");
  endtask

  task automatic t_wait_state();
    do_write(MEM_BASE + 32'h14, 4'b0111, 1, 32'h7777_1234, 4'h0, 1'b1, "R9 wait");
    do_read(MEM_BASE + 32'h14, 4'b0110, 2, "R9 readback");
  endtask

  task automatic t_io();
    do_write(IO_BASE + 32'h4, 4'b0011, 2, 32'h1010_2020, 4'h0, 1'b0, "R6 io write");
    do_read(IO_BASE + 32'h4, 4'b0010, 2, "R6 io read");
  endtask

  task automatic t_unclaimed();
    do_probe(MEM_BASE + 32'h10, 4'b0100, "R3 rsvd 0100");
    do_probe(MEM_BASE + 32'h10, 4'b0101, "R3 rsvd 0101");
    do_probe(MEM_BASE + 32'h10, 4'b1000, "R3 rsvd 1000");
    do_probe(MEM_BASE + 32'h10, 4'b1001, "R3 rsvd 1001");
    do_probe(MEM_BASE + 32'h10, 4'b1101, "R3 rsvd 1101");
    do_probe(MEM_BASE, 4'b0000, "R4 iack");
    do_probe(MEM_BASE, 4'b0001, "R4 special");
    do_probe(MEM_BASE, 4'b1010, "R4 cfg read");
    do_probe(MEM_BASE, 4'b1011, "R4 cfg write");
    do_probe(MEM_BASE + 32'h40, 4'b0111, "R5 out of window");
    do_probe(IO_BASE, 4'b0111, "R6 mem at io base");
    do_probe(MEM_BASE, 4'b0011, "R6 io at mem base");
    do_read(MEM_BASE, 4'b0110, WORDS, "R3 R4 R5 untouched");
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_and_read();
    t_byte_lanes();
    t_wrap();
    t_wait_state();
    t_io();
    t_unclaimed();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule